// File: doc/BRIEF.md
# FM Stereo Composite Multiplex Generator

This block forms the baseband composite signal for FM stereo broadcast from a stream of left and right audio samples. A new stereo pair arrives with a sample strobe at the audio rate. A separate tick runs at three times that rate, so each audio pair yields three composite samples that are spaced evenly in time. For every tick the block emits one composite value. That value is the halved sum channel, plus the difference channel multiplied by a 38 kHz subcarrier sine, plus a small 19 kHz pilot sine. The multiplication by the subcarrier gives double-sideband suppressed-carrier modulation of the difference signal.

The two sines come from 16-bit phase accumulators. Each accumulator advances by a fixed increment on every tick. The subcarrier increment is exactly twice the pilot increment, and the subcarrier accumulator starts at a fixed offset from the pilot accumulator, so the two carriers stay phase-locked. With the default offset of zero, the subcarrier crosses zero going upward at every zero crossing of the pilot. Both sines are read from a single quarter-wave table and mirrored into the other three quadrants. A sticky flag reports a difference channel that would not fit its width. The flag stays set until a clear input is asserted.

Top module: `stereo_mpx_gen`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `comp_out` is 0, `comp_vld` is 0 and `ovf_flag` is 0. The pilot phase is 0x0000 and the subcarrier phase equals the parameter SUB_PH0, which defaults to 0x0000.
- R2: A cycle with `tick` high produces exactly one cycle of `comp_vld` high two clock edges later, and `comp_vld` is never high otherwise. `comp_out` changes only together with `comp_vld` and holds its value between results.
- R3: The pilot phase accumulator is 16 bits wide. It adds 0x24C4 modulo 2^16 at every tick, keeps its value when there is no tick, and the phase in use at a tick is the value held before that tick's increment.
- R4: The subcarrier accumulator adds 0x4988 modulo 2^16 at every tick and always equals (2·pilot phase + SUB_PH0) mod 2^16.
- R5: For a phase p, the sine value is round(32767·sin(2π(k+0.5)/256)), where k = p[15:8] and rounding is half away from zero. A quarter-wave table of 64 entries, with mirroring and negation, produces this value.
- R6: `comp_out` is signed 18-bit and equals S + floor(D·s38/2^15) + floor(2949·s19/2^15). S and D are the held sum and difference values. s38 and s19 are the subcarrier and pilot sines of the tick's phases.
- R7: On a cycle with `smp_vld` high, S becomes floor((L+R)/2) and D becomes L−R, with L and R taken as signed 16-bit values. Both are held for all later ticks. A tick in the same cycle as the strobe still uses the previous S and D.
- R8: If L−R is above 32767 or below −32768, D saturates to 32767 or −32768, and `ovf_flag` is high from the next cycle on.
- R9: `ovf_flag` stays high until a cycle with `ovf_clr` high clears it for the next cycle. An overflowing sample in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe for a new left/right pair |
| left_in | input | 16 | Left audio sample, signed |
| right_in | input | 16 | Right audio sample, signed |
| tick | input | 1 | Output-rate tick, three per audio sample |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| comp_out | output | 18 | Composite sample, signed |
| comp_vld | output | 1 | High for one cycle per composite sample |
| ovf_flag | output | 1 | Sticky difference-overflow indicator |

## Verification
A composite value appears two edges after its tick: one edge for the table read and the captured sum and difference, and one edge for the registered mix. A strobe changes the held sum and difference, and the flag, one edge after it. The bench runs a behavioural model that applies these delays in integer arithmetic and compares `comp_vld`, `comp_out` and `ovf_flag` at every falling edge. The stimulus covers ticks spaced apart, back-to-back ticks, a tick in the same cycle as a strobe, overflow in both directions, and a clear that coincides with a new overflow. Explicit checks sample the flag on the falling edge right after the strobe that should set or clear it.

// File: rtl/stmux_pkg.sv
package stmux_pkg;

  localparam real STMUX_PI = 3.141592653589793;

  // Quarter-wave entry sampled at the middle of its bin, rounded to nearest.
  function automatic int quarter_sine(int idx, int n, int amp);
    real a;
    a = amp * $sin(STMUX_PI * (idx + 0.5) / (2.0 * n));
    return $rtoi(a + 0.5);
  endfunction

endpackage

// File: rtl/stmux_nco.sv
module stmux_nco #(
  parameter int              PH_W = 16,
  parameter logic [PH_W-1:0] INC  = 16'h24C4,
  parameter logic [PH_W-1:0] INIT = 16'h0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [PH_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst)     phase <= INIT;
    else if (en) phase <= phase + INC;
  end

  // R3 (and R4 for the subcarrier instance)
  step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (phase == PH_W'($past(phase) + INC)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase));

endmodule

// File: rtl/stmux_sine_rom.sv
module stmux_sine_rom
  import stmux_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int SIN_W = 16,
  parameter int QA    = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         ph,
  output logic signed [SIN_W-1:0] sin_o
);

  localparam int N   = 1 << QA;
  localparam int AMP = (1 << (SIN_W - 1)) - 1;

  logic signed [SIN_W-1:0] tbl [N];

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = SIN_W'(quarter_sine(i, N, AMP));
  end

  logic [1:0]              quad;
  logic [QA-1:0]           idx_raw, idx;
  logic signed [SIN_W-1:0] rd;
  logic                    neg_q;

  assign quad    = ph[PH_W-1 -: 2];
  assign idx_raw = ph[PH_W-3 -: QA];
  // second and fourth quadrants read the table backwards
  assign idx     = quad[0] ? ~idx_raw : idx_raw;

  // synchronous read, no reset on the data path so block RAM can hold it
  always_ff @(posedge clk) rd <= tbl[idx];

  always_ff @(posedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= quad[1];
  end

  assign sin_o = neg_q ? -rd : rd;

endmodule

// File: rtl/stmux_input.sv
module stmux_input #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic [DATA_W-1:0]        left_in,
  input  logic [DATA_W-1:0]        right_in,
  input  logic                     ovf_clr,
  output logic signed [DATA_W-1:0] sum_h,
  output logic signed [DATA_W-1:0] diff_s,
  output logic                     ovf_flag
);

  localparam int MAXV = 2 ** (DATA_W - 1) - 1;
  localparam int MINV = -(2 ** (DATA_W - 1));

  logic [DATA_W:0]   s_full, d_full;
  logic              d_ovf;
  logic [DATA_W-1:0] d_sat;

  assign s_full = {left_in[DATA_W-1], left_in} + {right_in[DATA_W-1], right_in};
  assign d_full = {left_in[DATA_W-1], left_in} - {right_in[DATA_W-1], right_in};
  assign d_ovf  = d_full[DATA_W] ^ d_full[DATA_W-1];
  assign d_sat  = !d_ovf         ? d_full[DATA_W-1:0] :
                  d_full[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} :
                                   {1'b0, {(DATA_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_h  <= '0;
      diff_s <= '0;
    end else if (smp_vld) begin
      sum_h  <= s_full[DATA_W:1];
      diff_s <= d_sat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    ovf_flag <= 1'b0;
    else if (smp_vld && d_ovf)  ovf_flag <= 1'b1;
    else if (ovf_clr)           ovf_flag <= 1'b0;
  end

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && ((int'($signed(left_in)) - int'($signed(right_in)) > MAXV) ||
                 (int'($signed(left_in)) - int'($signed(right_in)) < MINV)))
    |=> ovf_flag);

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(diff_s) && $stable(sum_h)));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !smp_vld) |=> !ovf_flag);

endmodule

// File: rtl/stmux_mixer.sv
module stmux_mixer #(
  parameter int                DATA_W = 16,
  parameter int                SIN_W  = 16,
  parameter int                OUT_W  = 18,
  parameter logic [DATA_W-1:0] GAIN   = 16'h0B85
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic signed [DATA_W-1:0] sum_h,
  input  logic signed [DATA_W-1:0] diff_s,
  input  logic signed [SIN_W-1:0]  sin_sub,
  input  logic signed [SIN_W-1:0]  sin_pil,
  output logic [OUT_W-1:0]         comp_out,
  output logic                     comp_vld
);

  localparam int PW = DATA_W + SIN_W;
  localparam int SH = SIN_W - 1;

  logic                      s1_vld;
  logic signed [DATA_W-1:0]  s1_sum, s1_diff;
  logic signed [PW-1:0]      p_sub;
  logic signed [PW:0]        p_pil;
  logic signed [DATA_W:0]    gain_s;
  logic signed [OUT_W-1:0]   t_sum, t_sub, t_pil, mix;

  assign gain_s = $signed({1'b0, GAIN});

  // stage 1: capture held audio alongside the table read of the same tick
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_sum  <= '0;
      s1_diff <= '0;
    end else begin
      s1_vld <= tick;
      if (tick) begin
        s1_sum  <= sum_h;
        s1_diff <= diff_s;
      end
    end
  end

  assign p_sub = s1_diff * sin_sub;
  assign p_pil = gain_s * sin_pil;
  assign t_sum = OUT_W'(s1_sum);
  assign t_sub = OUT_W'(p_sub >>> SH);
  assign t_pil = OUT_W'(p_pil >>> SH);
  assign mix   = t_sum + t_sub + t_pil;

  // stage 2: registered composite
  always_ff @(posedge clk) begin
    if (rst) begin
      comp_vld <= 1'b0;
      comp_out <= '0;
    end else begin
      comp_vld <= s1_vld;
      if (s1_vld) comp_out <= mix;
    end
  end

  // R2
  tick_to_s1_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> s1_vld);

  // R2
  s1_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> comp_vld);

  // R2
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> (!comp_vld && $stable(comp_out)));

endmodule

// File: rtl/stereo_mpx_gen.sv
module stereo_mpx_gen #(
  parameter int                DATA_W     = 16,
  parameter int                PH_W       = 16,
  parameter int                SIN_W      = 16,
  parameter int                LUT_QA     = 6,
  parameter logic [PH_W-1:0]   PILOT_INC  = 16'h24C4,
  parameter logic [PH_W-1:0]   SUB_PH0    = 16'h0000,
  parameter logic [DATA_W-1:0] PILOT_GAIN = 16'h0B85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  logic              tick,
  input  logic              ovf_clr,
  output logic [DATA_W+1:0] comp_out,
  output logic              comp_vld,
  output logic              ovf_flag
);

  localparam int              OUT_W   = DATA_W + 2;
  localparam logic [PH_W-1:0] SUB_INC = PILOT_INC << 1;

  logic [PH_W-1:0]          pil_ph, sub_ph, lock_ph;
  logic signed [SIN_W-1:0]  sin_pil, sin_sub;
  logic signed [DATA_W-1:0] sum_h, diff_s;

  stmux_input #(.DATA_W(DATA_W)) i_input (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .left_in(left_in),
    .right_in(right_in), .ovf_clr(ovf_clr), .sum_h(sum_h),
    .diff_s(diff_s), .ovf_flag(ovf_flag));

  stmux_nco #(.PH_W(PH_W), .INC(PILOT_INC), .INIT('0)) i_nco_pil (
    .clk(clk), .rst(rst), .en(tick), .phase(pil_ph));

  stmux_nco #(.PH_W(PH_W), .INC(SUB_INC), .INIT(SUB_PH0)) i_nco_sub (
    .clk(clk), .rst(rst), .en(tick), .phase(sub_ph));

  stmux_sine_rom #(.PH_W(PH_W), .SIN_W(SIN_W), .QA(LUT_QA)) i_rom_pil (
    .clk(clk), .rst(rst), .ph(pil_ph), .sin_o(sin_pil));

  stmux_sine_rom #(.PH_W(PH_W), .SIN_W(SIN_W), .QA(LUT_QA)) i_rom_sub (
    .clk(clk), .rst(rst), .ph(sub_ph), .sin_o(sin_sub));

  stmux_mixer #(.DATA_W(DATA_W), .SIN_W(SIN_W), .OUT_W(OUT_W),
                .GAIN(PILOT_GAIN)) i_mixer (
    .clk(clk), .rst(rst), .tick(tick), .sum_h(sum_h), .diff_s(diff_s),
    .sin_sub(sin_sub), .sin_pil(sin_pil), .comp_out(comp_out),
    .comp_vld(comp_vld));

  assign lock_ph = (pil_ph << 1) + SUB_PH0;

  // R4
  sub_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sub_ph == lock_ph);

endmodule

// File: tb/test_stereo_mpx_gen.sv
module test_stereo_mpx_gen;

  localparam int  CLK_P  = 10;
  localparam int  QA     = 6;
  localparam int  NQ     = 1 << QA;
  localparam int  P_INC  = 'h24C4;
  localparam int  S_INC  = 'h4988;
  localparam int  S_PH0  = 0;
  localparam int  GAIN   = 2949;
  localparam real PI_R   = 3.141592653589793;

  logic        clk = 0, rst = 1, smp_vld = 0, tick = 0, ovf_clr = 0;
  logic [15:0] left_in = 0, right_in = 0;
  logic [17:0] comp_out;
  logic        comp_vld, ovf_flag;

  int n_chk = 0, n_fail = 0;
  string tag = "R6";
  int unsigned seed = 32'h1234_5678;

  // model state
  int mp19, mp38, msum, mdiff, mflag;
  int m_val1, m_out2;
  bit m_vld1, m_vld2;

  stereo_mpx_gen i_stereo_mpx_gen (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .left_in(left_in),
    .right_in(right_in), .tick(tick), .ovf_clr(ovf_clr),
    .comp_out(comp_out), .comp_vld(comp_vld), .ovf_flag(ovf_flag));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R5: full-circle reference sine
  function automatic int sref(int ph);
    int  k;
    real x;
    k = (ph >> (14 - QA)) & (4 * NQ - 1);
    x = 32767.0 * $sin(2.0 * PI_R * (k + 0.5) / (4.0 * NQ));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    int l, r, d;
    if (rst) begin
      mp19 = 0; mp38 = S_PH0; msum = 0; mdiff = 0; mflag = 0;
      m_vld1 = 0; m_vld2 = 0; m_val1 = 0; m_out2 = 0;
    end else begin
      m_vld2 = m_vld1;
      if (m_vld1) m_out2 = m_val1;
      m_vld1 = tick;
      if (tick) begin
        m_val1 = msum + ((mdiff * sref(mp38)) >>> 15) + ((GAIN * sref(mp19)) >>> 15);
        mp19 = (mp19 + P_INC) & 'hFFFF;
        mp38 = (mp38 + S_INC) & 'hFFFF;
      end
      if (smp_vld) begin
        l = int'($signed(left_in));
        r = int'($signed(right_in));
        d = l - r;
        msum = (l + r) >>> 1;
        if (d > 32767) begin mdiff = 32767; mflag = 1; end
        else if (d < -32768) begin mdiff = -32768; mflag = 1; end
        else begin
          mdiff = d;
          if (ovf_clr) mflag = 0;
        end
      end else if (ovf_clr) mflag = 0;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    int a;
    if (!rst) begin
      chk(comp_vld === m_vld2, "R2 valid strobe", int'(comp_vld), int'(m_vld2));
      a = int'($signed(comp_out));
      chk(a == m_out2, {tag, " composite"}, a, m_out2);
      chk(int'(ovf_flag) == mflag, "R8 R9 flag", int'(ovf_flag), mflag);
    end
  end

  task automatic put_smp(int l, int r, bit clr = 0, bit tk = 0);
    @(negedge clk);
    smp_vld = 1; left_in = 16'(l); right_in = 16'(r); ovf_clr = clr; tick = tk;
    @(negedge clk);
    smp_vld = 0; ovf_clr = 0; tick = 0;
  endtask

  task automatic tick_n(int n, int gap);
    repeat (n) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic burst(int n);
    @(negedge clk) tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int rnd16k();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 32001) - 16000;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(comp_vld == 0, "R1 comp_vld after reset", int'(comp_vld), 0);
    chk(comp_out == 0, "R1 comp_out after reset", int'(comp_out), 0);
    chk(ovf_flag == 0, "R1 ovf_flag after reset", int'(ovf_flag), 0);

    // R3 R5: silence leaves only the pilot, first tick at phase zero
    tag = "R3 R5 pilot only";
    put_smp(0, 0);
    tick_n(12, 1);

    // R4: pure difference exposes the subcarrier
    tag = "R4 subcarrier";
    put_smp(12000, -12000);
    tick_n(12, 1);

    // R6 R7: mixed programme, three ticks per sample
    tag = "R6 R7 mixed";
    for (int i = 0; i < 40; i++) begin
      put_smp(rnd16k(), rnd16k());
      tick_n(3, 1);
    end

    // R7: back-to-back ticks and a tick in the strobe cycle
    tag = "R7 hold and same-cycle tick";
    put_smp(5000, -7000);
    burst(5);
    put_smp(-9000, 3000, 0, 1);
    tick_n(3, 0);

    // R8: overflow in both directions
    tag = "R8 saturation";
    put_smp(30000, -30000);
    chk(ovf_flag == 1, "R8 flag after positive overflow", int'(ovf_flag), 1);
    tick_n(3, 1);
    put_smp(-30000, 30000);
    tick_n(3, 1);

    // R9: sticky, then clear, then overflow together with clear
    tag = "R9 sticky";
    put_smp(100, 200);
    tick_n(3, 1);
    chk(ovf_flag == 1, "R9 flag held through normal sample", int'(ovf_flag), 1);
    put_smp(100, 200, 1);
    chk(ovf_flag == 0, "R9 flag cleared", int'(ovf_flag), 0);
    put_smp(-32768, 32767, 1);
    chk(ovf_flag == 1, "R9 overflow wins over clear", int'(ovf_flag), 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    chk(ovf_flag == 0, "R9 standalone clear", int'(ovf_flag), 0);

    // R5: long run sweeps every quadrant of both carriers
    tag = "R5 R6 long run";
    put_smp(-20000, 11000);
    tick_n(300, 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule